// File: doc/BRIEF.md
# N-Queens Solution Counter

This block counts, entirely in hardware, the ways of placing N queens on an N×N board so that no two queens share a row, a column or a diagonal. A host presents N on `n_i` and pulses `start_i`. The block then runs an iterative depth-first search and uses no memory outside itself. When the search ends it raises `done_o` and holds the total on `count_o`.

The search puts one queen in each row. For every row it keeps a column mask, a left-diagonal mask and a right-diagonal mask. A square is free when the OR of the three masks has a zero in that position. A stack with one entry per row holds the candidates a row has not tried yet, together with the masks for that row. Each cycle does one of three things:
- It tries the lowest remaining candidate and removes it from the row's stack entry.
- It counts a solution when the queen goes into row N-1.
- It steps back one row when the current row has no candidates left.

The search ends when row 0 has no candidates left. The logic is meant to run at 50 MHz or faster.

Top module: `nq_counter`

## Requirements
- R1: During reset and after it, `busy_o`, `done_o` and `count_o` are all zero until the first accepted start.
- R2: When `start_i` is high while `busy_o` is low and `n_i` is in MIN_N..MAX_N (default 4..14), the next clock edge sets `busy_o` to 1, clears `done_o` and clears `count_o` to 0.
- R3: For an accepted N in range, `count_o` at completion equals the number of arrangements of N non-attacking queens on an N×N board (for N = 4,5,6,7,8,9 these are 2,10,4,40,92,352).
- R4: After a run completes, `done_o` stays 1 and `count_o` stays unchanged until the next accepted start.
- R5: When `start_i` is high while `busy_o` is low and `n_i` is outside MIN_N..MAX_N, `busy_o` is 1 for exactly one cycle and `count_o` is 0. After that cycle `done_o` rises with `count_o` still 0.
- R6: A start pulse while `busy_o` is 1 is ignored. The running search completes with the count for the N it was started with, and `busy_o` stays 1 after the ignored pulse.
- R7: `busy_o` and `done_o` are never both 1. `busy_o` falls only in the cycle where `done_o` rises. While busy, `count_o` never decreases.
- R8: A new start accepted while `done_o` is 1 begins an independent run, whose result does not depend on earlier runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request, taken when not busy |
| n_i | input | NW = clog2(MAX_N+1) | Board size N, sampled with an accepted start |
| busy_o | output | 1 | Search (or reject cycle) in progress |
| done_o | output | 1 | Result valid; held until the next accepted start |
| count_o | output | CNT_W | Solution count |

## Verification
The case hardest to reach from the ports is a start pulse that arrives in the middle of a search. If that pulse were accepted, it would quietly replace N and reset the row stack. The bench starts a 6-queens run, lets it get well into its backtracking, and then pulses start with N = 8. It checks that `busy_o` is still high and that the final count is 4, not 92. The reject path is reached with N values just below and just above the supported range, and with N = 0. Each run begins from the done state of the run before it, so stale stack contents would show up as a wrong count.

// File: rtl/nq_pkg.sv
package nq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_EMPTY  = 2'd2,
    ST_DONE   = 2'd3
  } nq_state_e;
endpackage

// File: rtl/nq_rst_sync.sv
module nq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/nq_step.sv
// One search step: pick lowest candidate, derive next-row masks.
module nq_step #(
  parameter int MAX_N = 14
) (
  input  logic [MAX_N-1:0] full_i,
  input  logic [MAX_N-1:0] cand_i,
  input  logic [MAX_N-1:0] col_i,
  input  logic [MAX_N-1:0] ld_i,
  input  logic [MAX_N-1:0] rd_i,
  output logic             has_cand_o,
  output logic [MAX_N-1:0] rest_o,
  output logic [MAX_N-1:0] col_n_o,
  output logic [MAX_N-1:0] ld_n_o,
  output logic [MAX_N-1:0] rd_n_o,
  output logic [MAX_N-1:0] free_n_o
);
  logic [MAX_N-1:0] pick;

  always_comb begin
    pick       = cand_i & (~cand_i + {{(MAX_N-1){1'b0}}, 1'b1});
    has_cand_o = |cand_i;
    rest_o     = cand_i & ~pick;
    col_n_o    = col_i | pick;
    ld_n_o     = ((ld_i | pick) << 1) & full_i;
    rd_n_o     = (rd_i | pick) >> 1;
    free_n_o   = full_i & ~(col_n_o | ld_n_o | rd_n_o);
  end
endmodule

// File: rtl/nq_row_stack.sv
// Per-row storage: remaining candidates plus the masks for that row.
module nq_row_stack #(
  parameter int MAX_N = 14,
  parameter int NW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en_i,
  input  logic [NW-1:0]    upd_addr_i,
  input  logic [MAX_N-1:0] upd_cand_i,
  input  logic             push_en_i,
  input  logic [NW-1:0]    push_addr_i,
  input  logic [MAX_N-1:0] push_cand_i,
  input  logic [MAX_N-1:0] push_col_i,
  input  logic [MAX_N-1:0] push_ld_i,
  input  logic [MAX_N-1:0] push_rd_i,
  input  logic [NW-1:0]    rd_addr_i,
  output logic [MAX_N-1:0] rd_cand_o,
  output logic [MAX_N-1:0] rd_col_o,
  output logic [MAX_N-1:0] rd_ld_o,
  output logic [MAX_N-1:0] rd_rd_o
);
  logic [MAX_N-1:0] cand_q [MAX_N];
  logic [MAX_N-1:0] col_q  [MAX_N];
  logic [MAX_N-1:0] ld_q   [MAX_N];
  logic [MAX_N-1:0] rd_q   [MAX_N];

  for (genvar g = 0; g < MAX_N; g++) begin : g_row
    logic push_hit;
    logic upd_hit;
    assign push_hit = push_en_i && (push_addr_i == NW'(g));
    assign upd_hit  = upd_en_i  && (upd_addr_i  == NW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cand_q[g] <= '0;
        col_q[g]  <= '0;
        ld_q[g]   <= '0;
        rd_q[g]   <= '0;
      end else if (push_hit) begin
        cand_q[g] <= push_cand_i;
        col_q[g]  <= push_col_i;
        ld_q[g]   <= push_ld_i;
        rd_q[g]   <= push_rd_i;
      end else if (upd_hit) begin
        cand_q[g] <= upd_cand_i;
      end
    end
  end

  assign rd_cand_o = cand_q[rd_addr_i];
  assign rd_col_o  = col_q[rd_addr_i];
  assign rd_ld_o   = ld_q[rd_addr_i];
  assign rd_rd_o   = rd_q[rd_addr_i];
endmodule

// File: rtl/nq_ctrl.sv
module nq_ctrl
  import nq_pkg::*;
#(
  parameter int MIN_N = 4,
  parameter int MAX_N = 14,
  parameter int NW    = 4,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NW-1:0]    n_i,
  input  logic             has_cand_i,
  input  logic [MAX_N-1:0] rest_i,
  input  logic [MAX_N-1:0] col_n_i,
  input  logic [MAX_N-1:0] ld_n_i,
  input  logic [MAX_N-1:0] rd_n_i,
  input  logic [MAX_N-1:0] free_n_i,
  output logic [NW-1:0]    row_o,
  output logic [MAX_N-1:0] full_o,
  output logic             upd_en_o,
  output logic [MAX_N-1:0] upd_cand_o,
  output logic             push_en_o,
  output logic [NW-1:0]    push_addr_o,
  output logic [MAX_N-1:0] push_cand_o,
  output logic [MAX_N-1:0] push_col_o,
  output logic [MAX_N-1:0] push_ld_o,
  output logic [MAX_N-1:0] push_rd_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [NW-1:0] N_LO = NW'(MIN_N);
  localparam logic [NW-1:0] N_HI = NW'(MAX_N);

  nq_state_e        state_q, state_d;
  logic [NW-1:0]    row_q, row_d;
  logic [NW-1:0]    n_q, n_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, n_ok, last_row;
  logic [MAX_N:0]   full_new_w, full_cur_w;

  assign accept     = start_i && (state_q != ST_SEARCH) && (state_q != ST_EMPTY);
  assign n_ok       = (n_i >= N_LO) && (n_i <= N_HI);
  assign full_new_w = ({{MAX_N{1'b0}}, 1'b1} << n_i) - 1'b1;
  assign full_cur_w = ({{MAX_N{1'b0}}, 1'b1} << n_q) - 1'b1;
  assign full_o     = full_cur_w[MAX_N-1:0];
  assign last_row   = (row_q == n_q - 1'b1);

  always_comb begin
    state_d     = state_q;
    row_d       = row_q;
    n_d         = n_q;
    cnt_d       = cnt_q;
    upd_en_o    = 1'b0;
    upd_cand_o  = rest_i;
    push_en_o   = 1'b0;
    push_addr_o = row_q + 1'b1;
    push_cand_o = free_n_i;
    push_col_o  = col_n_i;
    push_ld_o   = ld_n_i;
    push_rd_o   = rd_n_i;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          cnt_d = '0;
          row_d = '0;
          if (n_ok) begin
            state_d     = ST_SEARCH;
            n_d         = n_i;
            push_en_o   = 1'b1;
            push_addr_o = '0;
            push_cand_o = full_new_w[MAX_N-1:0];
            push_col_o  = '0;
            push_ld_o   = '0;
            push_rd_o   = '0;
          end else begin
            state_d = ST_EMPTY;
          end
        end
      end
      ST_EMPTY: begin
        state_d = ST_DONE;
      end
      ST_SEARCH: begin
        if (has_cand_i) begin
          upd_en_o = 1'b1;
          if (last_row) begin
            cnt_d = cnt_q + 1'b1;
          end else begin
            push_en_o = 1'b1;
            row_d     = row_q + 1'b1;
          end
        end else if (row_q == '0) begin
          state_d = ST_DONE;
        end else begin
          row_d = row_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      n_q     <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      n_q     <= n_d;
      cnt_q   <= cnt_d;
    end
  end

  assign row_o   = row_q;
  assign busy_o  = (state_q == ST_SEARCH) || (state_q == ST_EMPTY);
  assign done_o  = (state_q == ST_DONE);
  assign count_o = cnt_q;
endmodule

// File: rtl/nq_counter.sv
module nq_counter #(
  parameter int MIN_N = 4,
  parameter int MAX_N = 14,
  parameter int CNT_W = 20,
  localparam int NW   = $clog2(MAX_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NW-1:0]    n_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic             rst_sync_n;
  logic [NW-1:0]    row;
  logic [MAX_N-1:0] full, cand, col, ld, rd;
  logic             has_cand;
  logic [MAX_N-1:0] rest, col_n, ld_n, rd_n, free_n;
  logic             upd_en, push_en;
  logic [MAX_N-1:0] upd_cand, push_cand, push_col, push_ld, push_rd;
  logic [NW-1:0]    push_addr;

  nq_rst_sync rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  nq_row_stack #(.MAX_N(MAX_N), .NW(NW)) stack_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .upd_en_i   (upd_en),
    .upd_addr_i (row),
    .upd_cand_i (upd_cand),
    .push_en_i  (push_en),
    .push_addr_i(push_addr),
    .push_cand_i(push_cand),
    .push_col_i (push_col),
    .push_ld_i  (push_ld),
    .push_rd_i  (push_rd),
    .rd_addr_i  (row),
    .rd_cand_o  (cand),
    .rd_col_o   (col),
    .rd_ld_o    (ld),
    .rd_rd_o    (rd)
  );

  nq_step #(.MAX_N(MAX_N)) step_i (
    .full_i    (full),
    .cand_i    (cand),
    .col_i     (col),
    .ld_i      (ld),
    .rd_i      (rd),
    .has_cand_o(has_cand),
    .rest_o    (rest),
    .col_n_o   (col_n),
    .ld_n_o    (ld_n),
    .rd_n_o    (rd_n),
    .free_n_o  (free_n)
  );

  nq_ctrl #(.MIN_N(MIN_N), .MAX_N(MAX_N), .NW(NW), .CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .n_i        (n_i),
    .has_cand_i (has_cand),
    .rest_i     (rest),
    .col_n_i    (col_n),
    .ld_n_i     (ld_n),
    .rd_n_i     (rd_n),
    .free_n_i   (free_n),
    .row_o      (row),
    .full_o     (full),
    .upd_en_o   (upd_en),
    .upd_cand_o (upd_cand),
    .push_en_o  (push_en),
    .push_addr_o(push_addr),
    .push_cand_o(push_cand),
    .push_col_o (push_col),
    .push_ld_o  (push_ld),
    .push_rd_o  (push_rd),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .count_o    (count_o)
  );
endmodule

// File: rtl/nq_counter_chk.sv
module nq_counter_chk #(
  parameter int MIN_N = 4,
  parameter int MAX_N = 14,
  parameter int NW    = 4,
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [NW-1:0]    n_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o
);
  logic in_rng;
  assign in_rng = (n_i >= NW'(MIN_N)) && (n_i <= NW'(MAX_N));

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!busy_o && !done_o && count_o == '0);
    end
  end

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R7
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  // R7
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (count_o >= $past(count_o)));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && in_rng) |=> (busy_o && !done_o && count_o == '0));

  // R5
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !in_rng) |=> (busy_o && count_o == '0) ##1 (done_o && count_o == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(count_o)));

  // R6
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && count_o == '0) |=> (count_o <= CNT_W'(1)));
endmodule

bind nq_counter nq_counter_chk #(
  .MIN_N(MIN_N), .MAX_N(MAX_N), .NW(NW), .CNT_W(CNT_W)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start_i(start_i),
  .n_i    (n_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .count_o(count_o)
);

// File: tb/nq_counter_tb_top.sv
module nq_counter_tb_top;
  localparam int MIN_N = 4;
  localparam int MAX_N = 14;
  localparam int CNT_W = 20;
  localparam int NW    = $clog2(MAX_N + 1);

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [NW-1:0]    n_i;
  logic             busy_o;
  logic             done_o;
  logic [CNT_W-1:0] count_o;

  int checks;
  int errors;
  int cycles;
  logic done_prev;

  typedef struct {
    int n;
    int cnt;
  } exp_t;
  exp_t exp_q[$];

  nq_counter #(.MIN_N(MIN_N), .MAX_N(MAX_N), .CNT_W(CNT_W)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .n_i    (n_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .count_o(count_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Known solution totals, taken from the requirement list (R3, R5)
  function automatic int known_total(input int n);
    if (n < MIN_N || n > MAX_N) return 0;
    case (n)
      4: return 2;
      5: return 10;
      6: return 4;
      7: return 40;
      8: return 92;
      9: return 352;
      10: return 724;
      default: return -1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: push the expected result, then issue the start
  task automatic run_case(input int n);
    exp_t e;
    e.n   = n;
    e.cnt = known_total(n);
    exp_q.push_back(e);
    @(negedge clk);
    n_i     = NW'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2 / R5: busy with a cleared count one edge after the start
    check(busy_o && !done_o && count_o == '0,
          (n < MIN_N || n > MAX_N) ? "R5 busy-after-start" : "R2 busy-after-start",
          {busy_o, done_o}, 2);
    wait (done_o);
    @(negedge clk);
  endtask

  // Monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o && !done_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected-done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(count_o == CNT_W'(e.cnt),
              (e.n < MIN_N || e.n > MAX_N) ? "R5 out-of-range count" : "R3 solution count",
              int'(count_o), e.cnt);
      end
    end
    done_prev <= done_o;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    cycles    = 0;
    done_prev = 1'b0;
    start_i   = 1'b0;
    n_i       = '0;
    rst_n     = 1'b1;
    #3 rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_o, "R1 busy at reset", busy_o, 0);
    check(!done_o, "R1 done at reset", done_o, 0);
    check(count_o == '0, "R1 count at reset", int'(count_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && count_o == '0, "R1 idle after reset", int'(count_o), 0);

    // R3: several board sizes; each run after the first starts from done (R8)
    run_case(4);
    run_case(5);
    run_case(6);
    run_case(7);
    run_case(8);
    run_case(9);

    // R4: result held while idle in done
    repeat (6) @(negedge clk);
    check(done_o && !busy_o && count_o == CNT_W'(352), "R4 held result", int'(count_o), 352);

    // R5: out-of-range N below, above and zero
    run_case(3);
    run_case(15);
    run_case(0);

    // R8: valid run right after a rejected one
    run_case(5);

    // R6: start during busy is ignored
    begin
      exp_t e;
      e.n   = 6;
      e.cnt = 4;
      exp_q.push_back(e);
      @(negedge clk);
      n_i     = NW'(6);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) @(negedge clk);
      n_i     = NW'(8);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o && !done_o, "R6 busy after ignored start", busy_o, 1);
      wait (done_o);
      @(negedge clk);
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule